// File: doc/BRIEF.md
# SPI Error Flag and DMA Word Counter

This block sits next to an SPI port and tracks the things that can go wrong on it, together with the number of words left in a DMA transfer. It watches the slave-select input while the port is a bus master. When another master drives that line low, the block records a mode fault and turns the port into a disabled slave. The serial shifter reports transmit-underflow and receive-overflow events as single-cycle pulses. The block keeps each error as a sticky flag in a status register. A second copy of each flag lives in a DMA control register and is set only while a DMA transfer is marked active. If any sticky flag is set, a level error interrupt is driven.

A 16-bit word counter is loaded through the register bus and steps down once for every transferred word. Its step from one to zero ends the transfer and raises a one-cycle completion pulse. To stop a transfer early, software writes one, so that the next step completes it in the normal way. Writing zero makes the next step wrap to all ones, and no completion is reported for that step.

The register bus is a plain single-cycle write port with a combinational read mux. Reads have no side effects. Flags are cleared only by writing one to their bit. This block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `spi_err_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `ms_out`, `en_out`, `done_irq` and `err_irq` are low.
- R2: Each cycle with `word_step` high and no count write lowers the count register (address 3) by exactly one.
- R3: The step that takes the count from 1 to 0 raises `done_irq` for exactly one cycle, in the same cycle in which the count first reads 0.
- R4: Writing 1 to the count during a transfer makes the next step complete it, with the count at 0 and a `done_irq` pulse.
- R5: A step while the count is 0 wraps it to 0xFFFF and gives no `done_irq`.
- R6: A count write in the same cycle as a step loads the written value, and the step is lost.
- R7: The status register (address 1) holds sticky flags: bit 0 is mode fault, bit 1 is transmit underflow, bit 2 is receive overflow.
- R8: The DMA control register (address 2) has the transfer-active bit at bit 0 (read/write). Its mirrored flags sit at bits 1 (mode fault), 2 (underflow) and 3 (overflow), and they are set only when an error occurs while bit 0 is 1.
- R9: A flag is cleared only by writing 1 to its bit. Writing 0 leaves it unchanged. A new error in the same cycle as a clear leaves the flag set.
- R10: The control register (address 0) holds port enable at bit 0, master select at bit 1 and fault-detect enable at bit 2. With all three bits set, a low on `ss_n_in` that has passed two synchronising flops sets status bit 0 one cycle later and clears bits 0 and 1. The edge sequence is: the change is sampled at the first edge, the fault is detected after the second edge, and the registers update at the third edge. With detect enable at 0, a low `ss_n_in` has no effect.
- R11: `err_irq` is high whenever any of the six sticky flags is set, and low once all six are cleared.
- R12: `ms_out` and `en_out` follow control bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 ctrl, 1 status, 2 DMA ctrl, 3 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ss_n_in | input | 1 | Asynchronous slave-select input, active low |
| tx_underflow | input | 1 | Transmit underflow pulse from the shifter |
| rx_overflow | input | 1 | Receive overflow pulse from the shifter |
| word_step | input | 1 | One DMA word transferred |
| ms_out | output | 1 | Port configured as master |
| en_out | output | 1 | Port enabled |
| done_irq | output | 1 | One-cycle DMA completion pulse |
| err_irq | output | 1 | Level error interrupt |

## Verification
The counter is driven through a plain countdown, an early stop made by rewriting one partway through a long count, a step from zero, and a write that collides with a step. Together these separate the real completion edge from the wrap and from the load priority. The error flags are raised with DMA idle and with DMA active, which shows whether mirroring depends on the active bit. A clear that collides with a new error shows which of the two has priority. For the mode fault, the bench checks the exact cycle after the synchroniser, and it repeats the same input with detection turned off to tell an enabled fault from a plain low line.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DMA  = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_ERR   = 3;
  localparam int unsigned ERR_FAULT = 0;
  localparam int unsigned ERR_UNDER = 1;
  localparam int unsigned ERR_OVER  = 2;

  localparam int unsigned CTL_PORT_EN = 0;
  localparam int unsigned CTL_MASTER  = 1;
  localparam int unsigned CTL_DET_EN  = 2;
  localparam int unsigned CTL_W       = 3;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_sticky_flags.sv
module spi_sticky_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q[b] <= 1'b0;
        else        flag_q[b] <= set_i[b] | (flag_q[b] & ~clr_i[b]);
      end

      // R9: an arriving error beats a simultaneous clear
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> flag_q[b]);
      // R9: without a clear, a set flag stays set
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[b] && !clr_i[b]) |=> flag_q[b]);
    end
  endgenerate

  assign flags_o = flag_q;
endmodule

// File: rtl/spi_dma_word_counter.sv
module spi_dma_word_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_q;
  logic         done_q;
  logic         finishing;

  assign finishing = step_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      done_q <= 1'b0;
    end else begin
      done_q <= finishing;
      if (load_i)      cnt_q <= load_val_i;
      else if (step_i) cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;
  assign done_o  = done_q;

  // R3: completion is reported together with a zero count
  a_r3_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == ZERO));
  // R3: completion is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: stepping past zero wraps and stays silent
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && cnt_q == ZERO) |=> (cnt_q == ALL1 && !done_q));
  // R6: a load wins over a step
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/spi_err_ctrl.sv
module spi_err_ctrl
  import spi_err_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ss_n_in,
  input  logic              tx_underflow,
  input  logic              rx_overflow,
  input  logic              word_step,
  output logic              ms_out,
  output logic              en_out,
  output logic              done_irq,
  output logic              err_irq
);
  localparam int unsigned DMA_W = NUM_ERR + 1;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic wr_ctrl, wr_stat, wr_dma, wr_cnt;
  assign wr_ctrl = reg_we && (sel == REG_CTRL);
  assign wr_stat = reg_we && (sel == REG_STAT);
  assign wr_dma  = reg_we && (sel == REG_DMA);
  assign wr_cnt  = reg_we && (sel == REG_CNT);

  // ---------------- slave-select synchroniser ----------------
  logic ss_sync;
  spi_ss_sync #(.STAGES(SS_STAGES)) u_ss_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ss_n_in),
    .sync_o (ss_sync)
  );

  // ---------------- control register and fault demotion ----------------
  logic [CTL_W-1:0] ctrl_q;
  logic             fault_hit;

  assign fault_hit = ctrl_q[CTL_DET_EN] && ctrl_q[CTL_MASTER] &&
                     ctrl_q[CTL_PORT_EN] && !ss_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTL_W-1:0];
      if (fault_hit) begin
        ctrl_q[CTL_MASTER]  <= 1'b0;
        ctrl_q[CTL_PORT_EN] <= 1'b0;
      end
    end
  end

  assign ms_out = ctrl_q[CTL_MASTER];
  assign en_out = ctrl_q[CTL_PORT_EN];

  // ---------------- DMA active bit ----------------
  logic dma_active_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      dma_active_q <= 1'b0;
    else if (wr_dma) dma_active_q <= reg_wdata[0];
  end

  // ---------------- sticky error flags ----------------
  logic [NUM_ERR-1:0] err_evt;
  logic [NUM_ERR-1:0] stat_clr, dma_clr, dma_set;
  logic [NUM_ERR-1:0] stat_flags, dma_flags;

  always_comb begin
    err_evt            = '0;
    err_evt[ERR_FAULT] = fault_hit;
    err_evt[ERR_UNDER] = tx_underflow;
    err_evt[ERR_OVER]  = rx_overflow;
  end

  assign stat_clr = wr_stat ? reg_wdata[NUM_ERR-1:0] : '0;
  assign dma_clr  = wr_dma  ? reg_wdata[NUM_ERR:1]   : '0;
  assign dma_set  = dma_active_q ? err_evt : '0;

  spi_sticky_flags #(.N(NUM_ERR)) u_stat_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (err_evt),
    .clr_i  (stat_clr),
    .flags_o(stat_flags)
  );

  spi_sticky_flags #(.N(NUM_ERR)) u_dma_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (dma_set),
    .clr_i  (dma_clr),
    .flags_o(dma_flags)
  );

  assign err_irq = (|stat_flags) | (|dma_flags);

  // ---------------- DMA word counter ----------------
  logic [DATA_W-1:0] cnt_val;
  spi_dma_word_counter #(.W(DATA_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wr_cnt),
    .load_val_i(reg_wdata),
    .step_i    (word_step),
    .count_o   (cnt_val),
    .done_o    (done_irq)
  );

  // ---------------- read mux ----------------
  logic [DMA_W-1:0] dma_view;
  assign dma_view = {dma_flags, dma_active_q};

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_CTRL: reg_rdata[CTL_W-1:0]   = ctrl_q;
      REG_STAT: reg_rdata[NUM_ERR-1:0] = stat_flags;
      REG_DMA:  reg_rdata[DMA_W-1:0]   = dma_view;
      REG_CNT:  reg_rdata              = cnt_val;
      default:  reg_rdata              = '0;
    endcase
  end

  // R10: a detected fault demotes and disables the port
  a_r10_demote: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (!ms_out && !en_out));
  // R10: a detected fault lands in the status flags
  a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> stat_flags[ERR_FAULT]);
  // R8: mirrored flags stay clear while DMA is idle
  a_r8_idle_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_active_q && dma_flags == '0) |=> (dma_flags == '0));
  // R11: the interrupt rises only after some error event
  a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> ($past(err_evt) != '0));
endmodule

// File: tb/spi_err_ctrl_bench.sv
module spi_err_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ss_n_in = 1'b1;
  logic        tx_underflow = 1'b0;
  logic        rx_overflow = 1'b0;
  logic        word_step = 1'b0;
  logic        ms_out, en_out, done_irq, err_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  spi_err_ctrl u_spi_err_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_n_in(ss_n_in),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
    .word_step(word_step), .ms_out(ms_out), .en_out(en_out),
    .done_irq(done_irq), .err_irq(err_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step();
    word_step = 1'b1; cycle(); word_step = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg", v, 16'h0);
    end
    check("R1 irqs/outs", {12'h0, ms_out, en_out, done_irq, err_irq}, 16'h0);
  endtask

  task automatic t_countdown();
    logic [15:0] v;
    wr(2'd3, 16'd3);
    step(); rd(2'd3, v); check("R2 3->2", v, 16'd2);
    check("R3 no done at 2", {15'h0, done_irq}, 16'h0);
    step(); rd(2'd3, v); check("R2 2->1", v, 16'd1);
    step(); rd(2'd3, v); check("R3 count 0", v, 16'd0);
    check("R3 done pulse", {15'h0, done_irq}, 16'h1);
    cycle(); check("R3 pulse ends", {15'h0, done_irq}, 16'h0);
  endtask

  task automatic t_early_end();
    logic [15:0] v;
    wr(2'd3, 16'd100);
    step(); rd(2'd3, v); check("R4 100->99", v, 16'd99);
    wr(2'd3, 16'd1);
    step(); rd(2'd3, v); check("R4 early zero", v, 16'd0);
    check("R4 early done", {15'h0, done_irq}, 16'h1);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(2'd3, 16'd0);
    step(); rd(2'd3, v); check("R5 wrap value", v, 16'hFFFF);
    check("R5 no done", {15'h0, done_irq}, 16'h0);
  endtask

  task automatic t_load_vs_step();
    logic [15:0] v;
    word_step = 1'b1;
    wr(2'd3, 16'd5);
    word_step = 1'b0;
    rd(2'd3, v); check("R6 write wins", v, 16'd5);
  endtask

  task automatic t_errors_idle();
    logic [15:0] v;
    tx_underflow = 1'b1; cycle(); tx_underflow = 1'b0;
    rd(2'd1, v); check("R7 underflow bit1", v, 16'h2);
    rd(2'd2, v); check("R8 no copy when idle", v, 16'h0);
    check("R11 irq set", {15'h0, err_irq}, 16'h1);
    wr(2'd1, 16'h0); rd(2'd1, v); check("R9 write 0 keeps", v, 16'h2);
    wr(2'd1, 16'h2); rd(2'd1, v); check("R9 w1c", v, 16'h0);
    check("R11 irq clear", {15'h0, err_irq}, 16'h0);
  endtask

  task automatic t_errors_dma();
    logic [15:0] v;
    wr(2'd2, 16'h1);
    rx_overflow = 1'b1; cycle(); rx_overflow = 1'b0;
    rd(2'd1, v); check("R7 overflow bit2", v, 16'h4);
    rd(2'd2, v); check("R8 copy bit3", v, 16'h9);
    wr(2'd2, 16'h9); rd(2'd2, v); check("R9 dma w1c", v, 16'h1);
    check("R11 irq from stat", {15'h0, err_irq}, 16'h1);
    wr(2'd1, 16'h4);
    check("R11 irq all clear", {15'h0, err_irq}, 16'h0);
    wr(2'd2, 16'h0);
  endtask

  task automatic t_set_beats_clear();
    logic [15:0] v;
    tx_underflow = 1'b1; cycle(); tx_underflow = 1'b0;
    tx_underflow = 1'b1;
    wr(2'd1, 16'h2);
    tx_underflow = 1'b0;
    rd(2'd1, v); check("R9 set beats clear", v, 16'h2);
    wr(2'd1, 16'h2);
  endtask

  task automatic t_fault();
    logic [15:0] v;
    wr(2'd0, 16'h7);
    check("R12 ms/en up", {14'h0, ms_out, en_out}, 16'h3);
    ss_n_in = 1'b0;
    cycle(); cycle();
    rd(2'd1, v); check("R10 not yet flagged", v, 16'h0);
    cycle();
    rd(2'd1, v); check("R10 fault flag", v, 16'h1);
    rd(2'd0, v); check("R10 demoted ctrl", v, 16'h4);
    check("R12 ms/en down", {14'h0, ms_out, en_out}, 16'h0);
    ss_n_in = 1'b1;
    cycle(); cycle();
    wr(2'd1, 16'h1);
  endtask

  task automatic t_fault_off();
    logic [15:0] v;
    wr(2'd0, 16'h3);
    ss_n_in = 1'b0;
    for (int i = 0; i < 5; i++) cycle();
    rd(2'd1, v); check("R10 disabled no flag", v, 16'h0);
    rd(2'd0, v); check("R10 disabled ctrl kept", v, 16'h3);
    ss_n_in = 1'b1;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_countdown();
    t_early_end();
    t_wrap();
    t_load_vs_step();
    t_errors_idle();
    t_errors_dma();
    t_set_beats_clear();
    t_fault();
    t_fault_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule